// File: doc/BRIEF.md
# Dark-Frame and Shading Correction Stage

This stage sits in a camera preview pixel pipeline. Each valid cycle it takes one raw 10-bit pixel together with one 8-bit correction value that arrives on a memory-fed side stream. In subtract mode it removes the correction value from the pixel and clamps the result at zero. In shading mode it multiplies the pixel by the correction value, shifts the product right by a programmable count from 0 to 7, and saturates the result to 10 bits. Shading mode requires both the subtract enable and the shading enable. When shading is selected, no subtraction takes place.

Software programs the stage through a small register port. Software may write the register at any moment. Each frame-start pulse copies the enables and the shift count into shadow registers, and the datapath reads only those shadow copies. A pixel presented in the frame-start cycle already uses the new settings.

If correction is active and a valid pixel arrives without a valid correction value, that is an underrun. The pixel then passes through unchanged, correction stays off for the rest of the frame, and a sticky fail flag is set. Software clears the flag by writing one to it.

The pixel input and the output carry valid only. There is no back-pressure on either: every valid pixel is accepted, and it leaves exactly two cycles later. The correction stream uses valid/ready. The stage raises `cor_ready` only in cycles where it consumes a correction value, so a memory feed can step its address on `cor_valid && cor_ready`.

Top module: `dfs_correct`

## Requirements
- R1: After reset, `out_valid` is 0, the control register (address 0) reads 0 and the status register (address 1) reads 0.
- R2: The control register has three fields: bit 0 is the subtract enable, bit 1 is the shading enable, and bits 4:2 are the shift count. Bits 31:5 are reserved: they read 0 and writes to them are ignored.
- R3: A control write made during a frame does not change how pixels of that frame are processed. It takes effect at the next `frame_start` pulse, including the pixel in that same cycle.
- R4: When only the subtract enable is latched, the output is pixel minus correction value, clamped at 0.
- R5: When both enables are latched, the output is (pixel × correction) shifted right by the latched shift count, saturated to 1023.
- R6: When the shading enable is latched without the subtract enable, or neither enable is latched, pixels pass through unchanged, and a missing correction value is not a failure.
- R7: An underrun occurs when a pixel is valid, correction is active and `cor_valid` is 0. On an underrun, that pixel passes through unchanged and status bit 0 becomes 1. All later pixels of the frame also pass through unchanged, with `cor_ready` held at 0.
- R8: Correction resumes automatically at the next `frame_start` after an underrun.
- R9: Status bit 0 stays set across frames. Writing 1 to address 1 bit 0 clears it, and writing 0 has no effect. If a new underrun and a clear happen in the same cycle, the flag ends up set.
- R10: `out_valid` repeats `pix_valid` with a latency of exactly two clock cycles in every mode, and `out_data` belongs to that pixel.
- R11: `cor_ready` is 1 only in a cycle where `pix_valid` is 1 and correction is active for that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame; latches the settings |
| pix_valid | input | 1 | Raw pixel valid |
| pix_data | input | 10 | Raw pixel |
| cor_valid | input | 1 | Correction value valid |
| cor_data | input | 8 | Correction value |
| cor_ready | output | 1 | Correction value consumed this cycle |
| out_valid | output | 1 | Corrected pixel valid |
| out_data | output | 10 | Corrected pixel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 is control, 1 is status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The assertions assume that `pix_valid` is driven to a known value in every cycle after reset, so that the two-cycle latency relation holds. They also assume that status clears arrive only through `reg_wr` at address 1. The bench keeps to these assumptions: it drives every input at the falling edge, holds `pix_valid` low between pixels, and issues `frame_start` only in cycles without a register write. Underruns are produced on purpose by lowering `cor_valid` while correction is active. The sweeps then check the clamp and saturation boundaries across all eight shift counts.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_SUB  = 2'd1,
    MODE_MUL  = 2'd2
  } corr_mode_e;

  localparam int CTRL_ADDR      = 0;
  localparam int STAT_ADDR      = 1;
  localparam int CTRL_DARK_BIT  = 0;
  localparam int CTRL_SHADE_BIT = 1;
  localparam int CTRL_SFT_LSB   = 2;
endpackage

// File: rtl/dfs_regs.sv
module dfs_regs
  import dfs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int SFT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fail_set,
  output logic              dark_en,
  output logic              shade_en,
  output logic [SFT_W-1:0]  sft,
  output logic              fail_flag
);
  localparam int CTRL_BITS = CTRL_SFT_LSB + SFT_W;

  logic wr_ctrl, wr_stat;
  logic unused_wdata;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
  assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dark_en  <= 1'b0;
      shade_en <= 1'b0;
      sft      <= '0;
    end else if (wr_ctrl) begin
      dark_en  <= reg_wdata[CTRL_DARK_BIT];
      shade_en <= reg_wdata[CTRL_SHADE_BIT];
      sft      <= reg_wdata[CTRL_SFT_LSB +: SFT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       fail_flag <= 1'b0;
    else if (fail_set)                fail_flag <= 1'b1;
    else if (wr_stat && reg_wdata[0]) fail_flag <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata[CTRL_DARK_BIT]           = dark_en;
      reg_rdata[CTRL_SHADE_BIT]          = shade_en;
      reg_rdata[CTRL_SFT_LSB +: SFT_W]   = sft;
    end else if (reg_addr == ADDR_W'(STAT_ADDR)) begin
      reg_rdata[0] = fail_flag;
    end
  end
endmodule

// File: rtl/dfs_frame_ctl.sv
module dfs_frame_ctl
  import dfs_pkg::*;
#(
  parameter int SFT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic             cor_valid,
  input  logic             dark_en,
  input  logic             shade_en,
  input  logic [SFT_W-1:0] sft,
  output corr_mode_e       mode,
  output logic [SFT_W-1:0] sft_eff,
  output logic             cor_ready,
  output logic             underrun
);
  logic             sh_dark, sh_shade, drop;
  logic [SFT_W-1:0] sh_sft;
  logic             eff_dark, eff_shade, eff_drop, active;
  corr_mode_e       mode_req;

  assign eff_dark  = frame_start ? dark_en  : sh_dark;
  assign eff_shade = frame_start ? shade_en : sh_shade;
  assign sft_eff   = frame_start ? sft      : sh_sft;
  assign eff_drop  = frame_start ? 1'b0     : drop;

  always_comb begin
    if (eff_dark && eff_shade) mode_req = MODE_MUL;
    else if (eff_dark)         mode_req = MODE_SUB;
    else                       mode_req = MODE_PASS;
  end

  assign active    = (mode_req != MODE_PASS) && !eff_drop;
  assign underrun  = pix_valid && active && !cor_valid;
  assign cor_ready = pix_valid && active;
  assign mode      = (active && !underrun) ? mode_req : MODE_PASS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_dark  <= 1'b0;
      sh_shade <= 1'b0;
      sh_sft   <= '0;
      drop     <= 1'b0;
    end else begin
      if (frame_start) begin
        sh_dark  <= dark_en;
        sh_shade <= shade_en;
        sh_sft   <= sft;
        drop     <= 1'b0;
      end
      if (underrun) drop <= 1'b1;
    end
  end
endmodule

// File: rtl/dfs_datapath.sv
module dfs_datapath
  import dfs_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int COR_W = 8,
  parameter int SFT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [COR_W-1:0] in_cor,
  input  corr_mode_e       in_mode,
  input  logic [SFT_W-1:0] in_sft,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  localparam int PROD_W = PIX_W + COR_W;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic             s1_valid;
  logic [PIX_W-1:0] s1_pix;
  logic [COR_W-1:0] s1_cor;
  corr_mode_e       s1_mode;
  logic [SFT_W-1:0] s1_sft;

  logic [PIX_W:0]    diff;
  logic [PROD_W-1:0] prod, shifted;
  logic [PIX_W-1:0]  result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_cor   <= '0;
      s1_mode  <= MODE_PASS;
      s1_sft   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_pix   <= in_pix;
      s1_cor   <= in_cor;
      s1_mode  <= in_mode;
      s1_sft   <= in_sft;
    end
  end

  assign diff    = {1'b0, s1_pix} - {{(PIX_W + 1 - COR_W){1'b0}}, s1_cor};
  assign prod    = {{COR_W{1'b0}}, s1_pix} * {{PIX_W{1'b0}}, s1_cor};
  assign shifted = prod >> s1_sft;

  always_comb begin
    case (s1_mode)
      MODE_SUB: result = diff[PIX_W] ? '0 : diff[PIX_W-1:0];
      MODE_MUL: result = (|shifted[PROD_W-1:PIX_W]) ? PIX_MAX : shifted[PIX_W-1:0];
      default:  result = s1_pix;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      out_pix   <= result;
    end
  end
endmodule

// File: rtl/dfs_correct.sv
module dfs_correct
  import dfs_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COR_W  = 8,
  parameter int SFT_W  = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              cor_valid,
  input  logic [COR_W-1:0]  cor_data,
  output logic              cor_ready,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic             dark_en, shade_en, fail_flag, underrun;
  logic [SFT_W-1:0] sft, sft_eff;
  corr_mode_e       mode;

  dfs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFT_W(SFT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fail_set(underrun),
    .dark_en(dark_en), .shade_en(shade_en), .sft(sft), .fail_flag(fail_flag)
  );

  dfs_frame_ctl #(.SFT_W(SFT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .cor_valid(cor_valid), .dark_en(dark_en), .shade_en(shade_en), .sft(sft),
    .mode(mode), .sft_eff(sft_eff), .cor_ready(cor_ready), .underrun(underrun)
  );

  dfs_datapath #(.PIX_W(PIX_W), .COR_W(COR_W), .SFT_W(SFT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_pix(pix_data),
    .in_cor(cor_data), .in_mode(mode), .in_sft(sft_eff),
    .out_valid(out_valid), .out_pix(out_data)
  );
endmodule

// File: rtl/dfs_correct_chk.sv
module dfs_correct_chk
  import dfs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int SFT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              cor_ready,
  input logic              out_valid,
  input logic              underrun,
  input logic              fail_flag,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << (CTRL_SFT_LSB + SFT_W)) - 1);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(pix_valid, 2)));

  p_ready_needs_pixel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cor_ready |-> pix_valid);

  p_underrun_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> fail_flag);

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !(reg_wr && reg_addr == ADDR_W'(STAT_ADDR) && reg_wdata[0])) |=> fail_flag);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTRL_ADDR)) |-> ((reg_rdata & ~CTRL_MASK) == '0));
endmodule

bind dfs_correct dfs_correct_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SFT_W(SFT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .cor_ready(cor_ready),
  .out_valid(out_valid), .underrun(underrun), .fail_flag(fail_flag),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/test_dfs_correct.sv
module test_dfs_correct;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [9:0]  pix_data = '0;
  logic        cor_valid = 1'b0;
  logic [7:0]  cor_data = '0;
  logic        cor_ready;
  logic        out_valid;
  logic [9:0]  out_data;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  logic last_ready;
  bit finished = 0;

  int plist[8] = '{0, 1, 5, 100, 255, 256, 511, 1023};
  int clist[5] = '{0, 1, 5, 128, 255};

  always #5 clk = ~clk;

  dfs_correct i_dfs_correct (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .cor_valid(cor_valid), .cor_data(cor_data),
    .cor_ready(cor_ready), .out_valid(out_valid), .out_data(out_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix(input int p, input int c, input bit cv, input int exp, input string req);
    pix_valid = 1'b1; pix_data = 10'(p); cor_valid = cv; cor_data = 8'(c);
    #1 last_ready = cor_ready;
    @(negedge clk);
    pix_valid = 1'b0; cor_valid = 1'b0;
    chk("R10 no early valid", out_valid, 0);
    @(negedge clk);
    chk("R10 valid after two cycles", out_valid, 1);
    chk(req, out_data, exp);
  endtask

  function automatic int mul_exp(input int p, input int c, input int s);
    int v = (p * c) >>> s;
    return (v > 1023) ? 1023 : v;
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 status", d, 0);

    // R2 reserved bits and field readback
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 reserved read zero", d, 32'h1F);
    wr(0, 32'hA5A5_A508);
    rd(0, d); chk("R2 shift field", d, 32'h08);

    // R6 shading enable alone: pass through, no underrun
    wr(0, 32'h0000_0006);
    frame();
    pix(300, 2, 1'b1, 300, "R6 pass shade only");
    chk("R6 no ready", last_ready, 0);
    pix(700, 9, 1'b0, 700, "R6 pass no data");
    rd(1, d); chk("R6 no fail", d, 0);

    // R4 subtract sweep
    wr(0, 32'h0000_0001);
    frame();
    foreach (plist[i]) foreach (clist[j]) begin
      pix(plist[i], clist[j], 1'b1,
          (plist[i] > clist[j]) ? plist[i] - clist[j] : 0, "R4 subtract clamp");
      chk("R11 ready on active pixel", last_ready, 1);
    end

    // R5 shading sweep across all shifts
    for (int s = 0; s < 8; s++) begin
      wr(0, 32'(3 | (s << 2)));
      frame();
      foreach (plist[i]) foreach (clist[j])
        pix(plist[i], clist[j], 1'b1, mul_exp(plist[i], clist[j], s), "R5 multiply shift saturate");
    end

    // R3 mid-frame write takes effect next frame
    wr(0, 32'h0000_0001);
    frame();
    pix(100, 5, 1'b1, 95, "R3 before write");
    wr(0, 32'h0000_0007);
    pix(100, 5, 1'b1, 95, "R3 still subtract");
    frame();
    pix(100, 5, 1'b1, 250, "R3 new mode after frame start");

    // R10 burst back-to-back
    wr(0, 32'h0);
    frame();
    pix_valid = 1'b1; pix_data = 10'd11; @(negedge clk);
    chk("R10 burst c1", out_valid, 0);
    pix_data = 10'd22; @(negedge clk);
    chk("R10 burst c2", out_valid, 1); chk("R10 burst d0", out_data, 11);
    pix_data = 10'd33; @(negedge clk);
    pix_valid = 1'b0;
    chk("R10 burst c3", out_valid, 1); chk("R10 burst d1", out_data, 22);
    @(negedge clk);
    chk("R10 burst c4", out_valid, 1); chk("R10 burst d2", out_data, 33);
    @(negedge clk);
    chk("R10 burst end", out_valid, 0);

    // R7 underrun, R8 resume, R9 sticky and W1C
    wr(0, 32'h0000_0001);
    frame();
    pix(100, 5, 1'b1, 95, "R7 before underrun");
    pix(200, 5, 1'b0, 200, "R7 underrun pixel passes");
    rd(1, d); chk("R7 fail set", d, 1);
    pix(100, 5, 1'b1, 100, "R7 rest of frame uncorrected");
    chk("R7 ready low after drop", last_ready, 0);
    frame();
    pix(100, 5, 1'b1, 95, "R8 resumes next frame");
    rd(1, d); chk("R9 sticky across frame", d, 1);
    wr(1, 32'h0);
    rd(1, d); chk("R9 write zero no effect", d, 1);
    wr(1, 32'h1);
    rd(1, d); chk("R9 write one clears", d, 0);

    // R9 set wins over clear in the same cycle
    pix_valid = 1'b1; pix_data = 10'd50; cor_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
    @(negedge clk);
    pix_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1, d); chk("R9 set beats clear", d, 1);
    @(negedge clk);
    chk("R7 collision pixel passes", out_data, 50);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule